// File: doc/BRIEF.md
# Count/Compare interval timer

This block pairs a 32-bit cycle counter with a 32-bit compare register. When the counter equals the compare value, the block sets an interrupt flag. The flag stays high until software writes the compare register. Software reads and writes both registers through a small access port. The port has an enable, a register select, a write strobe, write data and combinational read data.

Counting depends on two things: a stop bit from a configuration register and the power state. The counter keeps running in sleep. It halts completely in deep-off, where the flag also cannot be set. A mode input makes the counter clear to zero on a match, so it works as a periodic divider. Without that mode the counter runs freely and wraps. In free-running mode, software must move the compare value forward after each interrupt.

Top module: `cct_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter becomes 0, the compare register becomes 0xFFFFFFFF and `tc_irq` becomes 0.
- R2: With `acc_en` high, `acc_sel`=0 selects the counter and `acc_sel`=1 selects the compare register. With `acc_we` also high, the selected register takes `acc_wdata` at the clock edge. `acc_rdata` shows the selected register combinationally while `acc_en` is high and shows 0 otherwise.
- R3: While the timer is active, the counter rises by exactly one on each clock edge and wraps from 0xFFFFFFFF to 0.
- R4: While `cfg_stop` is 1, the counter holds its value. When `cfg_stop` returns to 0, counting resumes from the held value.
- R5: `pwr_sleep` has no effect on counting. While `pwr_deepoff` is 1, the counter holds its value and the flag is not set, and deep-off overrides sleep.
- R6: `tc_irq` rises at the clock edge that follows the first cycle in which the registered counter equals the compare register.
- R7: Once set, `tc_irq` stays 1 until a compare-register write. A counter write does not clear it.
- R8: With `auto_clr`=1, the clock edge that ends a match cycle while the timer is active loads the counter with 0. Counting continues from 0 on the next edge.
- R9: A counter write takes priority over increment, auto-clear and halt. After the edge, the counter holds exactly the written value.
- R10: Writing the counter with the value already in the compare register raises `tc_irq` one edge after the write.
- R11: A compare write in a match cycle leaves `tc_irq` at 0 after that edge. Equality is then checked against the new compare value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access enable |
| acc_sel | input | 1 | 0 selects the counter, 1 selects the compare register |
| acc_we | input | 1 | Write strobe for the selected register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the selected register |
| cfg_stop | input | 1 | Stop bit from the configuration register |
| pwr_sleep | input | 1 | Sleep power state indication |
| pwr_deepoff | input | 1 | Deep-off power state indication |
| auto_clr | input | 1 | Clear the counter on a match |
| tc_irq | output | 1 | Sticky terminal-count interrupt |

## Verification
The bench measures when the flag rises relative to the counter reaching the compare value. A design that compared against the next counter value would raise it one edge too early. The bench runs a counter through 0xFFFFFFFF to catch a counter that saturates or skips at the wrap. It also writes the counter with the compare value to confirm that a direct load raises the interrupt, which an edge-triggered flag would miss.

Several checks cover how the flag is cleared and when counting stops. A compare write in a match cycle must leave the flag low at first and then re-arm it against the new value. A counter write must leave the flag set, so a design that cleared the flag on any write fails there. In deep-off, the bench expects both the counter and the flag to freeze. In sleep, it expects counting to go on, so a design that gated on either power input alone is caught.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int unsigned TMR_W = 32;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_CMP   = 1'b1
    } cct_sel_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE  = 2'd0,
        PWR_SLEEP   = 2'd1,
        PWR_DEEPOFF = 2'd2
    } cct_pwr_e;

    typedef struct packed {
        logic        wr_count;
        logic        wr_cmp;
        logic        run;
        logic        deep;
    } cct_ctl_t;

    // Deep-off dominates sleep
    function automatic cct_pwr_e decode_pwr(input logic sleep, input logic deepoff);
        if (deepoff)    return PWR_DEEPOFF;
        else if (sleep) return PWR_SLEEP;
        else            return PWR_ACTIVE;
    endfunction

    function automatic logic run_enable(input logic stop, input cct_pwr_e pwr);
        return !stop && (pwr != PWR_DEEPOFF);
    endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter
    import cct_pkg::*;
#(
    parameter int unsigned W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         deep,
    input  logic         auto_clr,
    input  logic         match,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt;
        if (wr_en)
            cnt_nxt = wr_data;
        else if (run_en && auto_clr && match)
            cnt_nxt = '0;
        else if (run_en)
            cnt_nxt = cnt + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    // R3 increment by one while active
    a_r3_increment: assert property (@(posedge clk) disable iff (rst)
        (run_en && !wr_en && !(auto_clr && match)) |=> (cnt == $past(cnt) + ONE));

    // R4/R5 hold while halted
    a_r4_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !wr_en) |=> $stable(cnt));

    a_r5_deep_holds: assert property (@(posedge clk) disable iff (rst)
        (deep && !wr_en) |=> $stable(cnt));

    // R8 auto clear
    a_r8_auto_clear: assert property (@(posedge clk) disable iff (rst)
        (run_en && auto_clr && match && !wr_en) |=> (cnt == '0));

    // R9 write wins
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == $past(wr_data)));

endmodule

// File: rtl/cct_compare.sv
module cct_compare
    import cct_pkg::*;
#(
    parameter int unsigned  W       = TMR_W,
    parameter logic [W-1:0] CMP_RST = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt,
    input  logic         deep,
    output logic [W-1:0] cmp,
    output logic         match,
    output logic         flag
);

    assign match = (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp  <= CMP_RST;
            flag <= 1'b0;
        end else begin
            if (wr_en) cmp <= wr_data;
            if (wr_en)
                flag <= 1'b0;
            else if (match && !deep)
                flag <= 1'b1;
        end
    end

    // R6 flag set after match
    a_r6_set_on_match: assert property (@(posedge clk) disable iff (rst)
        (match && !deep && !wr_en) |=> flag);

    // R7 sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr_en) |=> flag);

    // R11 compare write clears
    a_r11_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !flag);

    // R5 no rise in deep-off
    a_r5_deep_no_set: assert property (@(posedge clk) disable iff (rst)
        (!flag && deep) |=> !flag);

endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int unsigned  W       = TMR_W,
    parameter logic [W-1:0] CMP_RST = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         acc_en,
    input  logic         acc_sel,
    input  logic         acc_we,
    input  logic [W-1:0] acc_wdata,
    output logic [W-1:0] acc_rdata,
    input  logic         cfg_stop,
    input  logic         pwr_sleep,
    input  logic         pwr_deepoff,
    input  logic         auto_clr,
    output logic         tc_irq
);

    cct_ctl_t     ctl;
    cct_sel_e     sel;
    cct_pwr_e     pwr;
    logic [W-1:0] cnt;
    logic [W-1:0] cmp;
    logic         match;

    always_comb begin
        sel          = cct_sel_e'(acc_sel);
        pwr          = decode_pwr(pwr_sleep, pwr_deepoff);
        ctl.wr_count = acc_en && acc_we && (sel == SEL_COUNT);
        ctl.wr_cmp   = acc_en && acc_we && (sel == SEL_CMP);
        ctl.run      = run_enable(cfg_stop, pwr);
        ctl.deep     = (pwr == PWR_DEEPOFF);
    end

    cct_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run_en   (ctl.run),
        .deep     (ctl.deep),
        .auto_clr (auto_clr),
        .match    (match),
        .wr_en    (ctl.wr_count),
        .wr_data  (acc_wdata),
        .cnt      (cnt)
    );

    cct_compare #(.W(W), .CMP_RST(CMP_RST)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl.wr_cmp),
        .wr_data (acc_wdata),
        .cnt     (cnt),
        .deep    (ctl.deep),
        .cmp     (cmp),
        .match   (match),
        .flag    (tc_irq)
    );

    always_comb begin
        if (!acc_en)               acc_rdata = '0;
        else if (sel == SEL_CMP)   acc_rdata = cmp;
        else                       acc_rdata = cnt;
    end

    // R2 idle port reads zero
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> (acc_rdata == '0));

    // R1 reset state
    a_r1_reset_irq: assert property (@(posedge clk)
        rst |=> !tc_irq);

endmodule

// File: tb/cct_timer_tb.sv
module cct_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;

    // table: start value, edges to run, stop bit, expected count
    localparam logic [31:0] V_START [NVEC] = '{32'h10, 32'hFFFF_FFFE, 32'h100, 32'h7, 32'hABC};
    localparam int          V_RUN   [NVEC] = '{5, 3, 4, 0, 10};
    localparam logic        V_STOP  [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [31:0] V_EXP   [NVEC] = '{32'h15, 32'h1, 32'h100, 32'h7, 32'hAC6};

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_en, acc_sel, acc_we;
    logic [31:0] acc_wdata, acc_rdata;
    logic        cfg_stop, pwr_sleep, pwr_deepoff, auto_clr;
    logic        tc_irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    cct_timer dut_i (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_sel(acc_sel), .acc_we(acc_we),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .cfg_stop(cfg_stop),
        .pwr_sleep(pwr_sleep), .pwr_deepoff(pwr_deepoff), .auto_clr(auto_clr),
        .tc_irq(tc_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        acc_en = 1'b1; acc_we = 1'b1; acc_sel = sel; acc_wdata = d;
        tick();
        acc_en = 1'b0; acc_we = 1'b0; acc_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        acc_en = 1'b1; acc_we = 1'b0; acc_sel = sel;
        #1;
        v = acc_rdata;
        acc_en = 1'b0;
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        rst = 1'b1; acc_en = 0; acc_sel = 0; acc_we = 0; acc_wdata = '0;
        cfg_stop = 0; pwr_sleep = 0; pwr_deepoff = 0; auto_clr = 0;
        tick(); tick();
        // R1 reset state
        rd(1'b0, v); chk("R1 count reset", v, 32'h0);
        rd(1'b1, v); chk("R1 compare reset", v, 32'hFFFF_FFFF);
        chk("R1 irq reset", {31'b0, tc_irq}, 32'h0);
        #1; chk("R2 idle read zero", acc_rdata, 32'h0);
        rst = 1'b0;

        // table walk: R2 R3 R4 R9
        for (int i = 0; i < NVEC; i++) begin
            cfg_stop = V_STOP[i];
            wr(1'b0, V_START[i]);
            for (int k = 0; k < V_RUN[i]; k++) tick();
            rd(1'b0, v);
            chk($sformatf("R3/R4/R9 vector %0d", i), v, V_EXP[i]);
            cfg_stop = 1'b0;
        end

        // R2 compare write and readback
        wr(1'b1, 32'd100);
        rd(1'b1, v); chk("R2 compare readback", v, 32'd100);
        chk("R11 compare write clears irq", {31'b0, tc_irq}, 32'h0);

        // R6 timing of flag
        wr(1'b0, 32'd97);
        tick(); tick(); tick();
        rd(1'b0, v); chk("R6 count at compare", v, 32'd100);
        chk("R6 irq not yet", {31'b0, tc_irq}, 32'h0);
        tick();
        chk("R6 irq after match", {31'b0, tc_irq}, 32'h1);

        // R7 sticky, counter write does not clear
        for (int k = 0; k < 5; k++) tick();
        chk("R7 irq held", {31'b0, tc_irq}, 32'h1);
        wr(1'b0, 32'h0);
        chk("R7 count write keeps irq", {31'b0, tc_irq}, 32'h1);
        wr(1'b1, 32'h5000);
        chk("R7 compare write clears", {31'b0, tc_irq}, 32'h0);

        // R10 load count with compare value
        wr(1'b1, 32'h200);
        wr(1'b0, 32'h200);
        chk("R10 irq low right after load", {31'b0, tc_irq}, 32'h0);
        tick();
        chk("R10 irq after load", {31'b0, tc_irq}, 32'h1);

        // R8 auto clear
        auto_clr = 1'b1;
        wr(1'b1, 32'd10);
        wr(1'b0, 32'd8);
        tick(); tick();
        rd(1'b0, v); chk("R8 count at compare", v, 32'd10);
        tick();
        rd(1'b0, v); chk("R8 count cleared", v, 32'd0);
        chk("R8 irq on auto clear", {31'b0, tc_irq}, 32'h1);
        tick();
        rd(1'b0, v); chk("R8 restart from zero", v, 32'd1);
        auto_clr = 1'b0;

        // R4 stop holds, resume
        cfg_stop = 1'b1;
        tick();
        rd(1'b0, held);
        for (int k = 0; k < 4; k++) tick();
        rd(1'b0, v); chk("R4 stop holds", v, held);
        cfg_stop = 1'b0;
        tick(); tick();
        rd(1'b0, v); chk("R4 resume", v, held + 32'd2);

        // R5 sleep runs
        pwr_sleep = 1'b1;
        rd(1'b0, held);
        tick(); tick(); tick();
        rd(1'b0, v); chk("R5 sleep counts", v, held + 32'd3);

        // R5 deep-off halts count and flag (with sleep also high)
        pwr_deepoff = 1'b1;
        tick();
        rd(1'b0, held);
        wr(1'b1, held);
        tick(); tick(); tick();
        rd(1'b0, v); chk("R5 deep-off holds count", v, held);
        chk("R5 deep-off blocks irq", {31'b0, tc_irq}, 32'h0);

        // R9 write while halted
        wr(1'b0, 32'h55);
        rd(1'b0, v); chk("R9 write while halted", v, 32'h55);
        wr(1'b0, held);
        pwr_deepoff = 1'b0; pwr_sleep = 1'b0;
        tick();
        chk("R5 irq once deep-off ends", {31'b0, tc_irq}, 32'h1);

        // R11 compare write during match cycle
        wr(1'b1, 32'd50);
        wr(1'b0, 32'd49);
        tick();
        rd(1'b0, v); chk("R11 count at match", v, 32'd50);
        wr(1'b1, 32'd51);
        chk("R11 irq low after write", {31'b0, tc_irq}, 32'h0);
        rd(1'b0, v); chk("R11 count moved on", v, 32'd51);
        tick();
        chk("R11 re-evaluated against new compare", {31'b0, tc_irq}, 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule